// File: doc/BRIEF.md
# SPI Slave Control-Register Port

This block is the serial front end to a peripheral's control registers. An SPI master selects the block by pulling chip select low and clocks bytes in mode 0. The first byte of each transfer is a command. Its top bits choose one of three access kinds: control register, frame buffer or SRAM. Each kind can be a read or a write. For a register access, the low six bits name one of 64 eight-bit registers.

Register accesses are carried out in full inside the block. A read returns the register on MISO during the second byte. A write stores the second MOSI byte and raises a one-cycle write strobe carrying the address and data. Frame-buffer and SRAM commands are only decoded. Each one raises a one-cycle strobe, and its data phase is left to other logic.

While the command byte shifts in, MISO always carries an 8-bit status word. The word is taken from an input port as chip select falls. The serial inputs are sampled by the block's own clock, which must be several times faster than the serial clock. The inputs are assumed to be synchronous to that clock already.

Top module: `spi_regif`

## Requirements
- R1: While reset is asserted and right after it, MISO is 0, every strobe output is low and all 64 registers read as 0x00.
- R2: MOSI is sampled on rising serial-clock edges, most significant bit first. MISO changes only after a falling serial-clock edge while chip select is low.
- R3: During the command byte, MISO returns MSB first the status word present on the status input when chip select fell. This holds for every command value.
- R4: A command with bits 7:6 = 10 is a register read of address bits 5:0. The register's contents are returned MSB first on MISO during the second byte.
- R5: A command with bits 7:6 = 11 is a register write of address bits 5:0. The second MOSI byte is stored at that address. The write strobe is high for exactly one clock, the clock after the edge on which the eighth data bit is seen, and it carries the address and the data.
- R6: A command with bits 7:5 = 001 pulses the frame-buffer read strobe, and 011 pulses the frame-buffer write strobe. Each pulse is one clock wide and follows the command byte.
- R7: A command with bits 7:5 = 000 pulses the SRAM read strobe, and 010 pulses the SRAM write strobe. Each pulse is one clock wide and follows the command byte.
- R8: Raising chip select at any point aborts the transfer. A write data byte that is cut short raises no strobe and changes no register, and the next transfer starts again with a command byte.
- R9: MISO is 0 while chip select is high. It is also 0 during every byte after the command byte, except the data byte of a register read.
- R10: Bytes sent after the second byte of a register access have no effect. They cause no further write, and MISO is 0 during them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idles low (mode 0) |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| status_in | input | 8 | Status word returned during the command byte |
| wr_stb | output | 1 | One-clock register write strobe |
| wr_addr | output | 6 | Register address of the write |
| wr_data | output | 8 | Register data of the write |
| fb_rd_stb | output | 1 | Frame-buffer read command decoded |
| fb_wr_stb | output | 1 | Frame-buffer write command decoded |
| sram_rd_stb | output | 1 | SRAM read command decoded |
| sram_wr_stb | output | 1 | SRAM write command decoded |

## Verification
A serial-clock transition driven between clock edges is seen as an edge at the next rising clock edge. Shift state and the MISO register update on that same clock edge. Strobes are high during the following clock, and a written register holds its new value one clock after that. The bench holds each serial-clock level for three clock cycles. It samples MISO just before raising the serial clock, when the value loaded after the previous fall has settled. It samples MISO again just before dropping the serial clock, to confirm the value held. Strobes are counted on every falling clock edge and compared per transfer, so a pulse that comes late or repeats is caught.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

  typedef enum logic [1:0] {
    ST_CMD,
    ST_RDATA,
    ST_WDATA,
    ST_SKIP
  } ctrl_state_t;

  typedef enum logic [2:0] {
    ACC_REG_RD,
    ACC_REG_WR,
    ACC_FB_RD,
    ACC_FB_WR,
    ACC_SRAM_RD,
    ACC_SRAM_WR
  } acc_kind_t;

  // Top bit set: register access, next bit gives direction.
  // Otherwise bit 5 picks frame buffer (1) or SRAM (0), bit 6 the direction.
  function automatic acc_kind_t decode_cmd(input logic [7:0] cmd);
    acc_kind_t k;
    if (cmd[7]) begin
      k = cmd[6] ? ACC_REG_WR : ACC_REG_RD;
    end else begin
      case ({cmd[6], cmd[5]})
        2'b01:   k = ACC_FB_RD;
        2'b11:   k = ACC_FB_WR;
        2'b00:   k = ACC_SRAM_RD;
        default: k = ACC_SRAM_WR;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/spi_regif_edge.sv
module spi_regif_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  output logic rise,
  output logic fall
);

  logic sclk_q;
  logic sclk_d;

  always_comb begin
    sclk_d = sclk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_d;
  end

  assign rise = !cs_n &&  sclk && !sclk_q;
  assign fall = !cs_n && !sclk &&  sclk_q;

endmodule

// File: rtl/spi_regif_rx.sv
module spi_regif_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rise,
  input  logic              mosi,
  output logic              byte_done,
  output logic [DATA_W-1:0] byte_val,
  output logic              at_boundary
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;

  assign byte_val    = {sh_q[DATA_W-2:0], mosi};
  assign byte_done   = rise && (cnt_q == LAST_BIT);
  assign at_boundary = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (cs_n) begin
      cnt_d = '0;
    end else if (rise) begin
      sh_d  = byte_val;
      cnt_d = (cnt_q == LAST_BIT) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  // R8: a deselect always leaves the bit counter at the byte start
  a_r8_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cnt_q == '0));

endmodule

// File: rtl/spi_regif_ctrl.sv
module spi_regif_ctrl
  import spi_regif_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] byte_val,
  output logic              rd_phase,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data,
  output logic              fb_rd_stb,
  output logic              fb_wr_stb,
  output logic              sram_rd_stb,
  output logic              sram_wr_stb
);

  ctrl_state_t       state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdat_q, wdat_d;
  logic              wstb_q, wstb_d;
  logic [3:0]        mstb_q, mstb_d;
  acc_kind_t         kind;
  logic              cmd_end;

  always_comb begin
    kind    = decode_cmd(byte_val[DATA_W-1 -: 8]);
    cmd_end = byte_done && (state_q == ST_CMD);
    state_d = state_q;
    addr_d  = addr_q;
    wdat_d  = wdat_q;
    wstb_d  = 1'b0;
    mstb_d  = 4'b0000;
    if (cs_n) begin
      state_d = ST_CMD;
    end else if (byte_done) begin
      case (state_q)
        ST_CMD: begin
          case (kind)
            ACC_REG_RD:  begin state_d = ST_RDATA; addr_d = byte_val[ADDR_W-1:0]; end
            ACC_REG_WR:  begin state_d = ST_WDATA; addr_d = byte_val[ADDR_W-1:0]; end
            default:     state_d = ST_SKIP;
          endcase
        end
        ST_WDATA: begin
          state_d = ST_SKIP;
          wstb_d  = 1'b1;
          wdat_d  = byte_val;
        end
        default: state_d = ST_SKIP;
      endcase
    end
    if (cmd_end && !cs_n) begin
      mstb_d[0] = (kind == ACC_FB_RD);
      mstb_d[1] = (kind == ACC_FB_WR);
      mstb_d[2] = (kind == ACC_SRAM_RD);
      mstb_d[3] = (kind == ACC_SRAM_WR);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CMD;
      addr_q  <= '0;
      wdat_q  <= '0;
      wstb_q  <= 1'b0;
      mstb_q  <= 4'b0000;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      wdat_q  <= wdat_d;
      wstb_q  <= wstb_d;
      mstb_q  <= mstb_d;
    end
  end

  assign rd_phase    = (state_q == ST_RDATA);
  assign acc_addr    = addr_q;
  assign wr_stb      = wstb_q;
  assign wr_data     = wdat_q;
  assign fb_rd_stb   = mstb_q[0];
  assign fb_wr_stb   = mstb_q[1];
  assign sram_rd_stb = mstb_q[2];
  assign sram_wr_stb = mstb_q[3];

  // R5: write strobe never lasts beyond one clock
  a_r5_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R6/R7: at most one access strobe at a time, each one clock wide
  a_r6_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb, fb_rd_stb, fb_wr_stb, sram_rd_stb, sram_wr_stb}));
  a_r7_mode_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_rd_stb || fb_wr_stb || sram_rd_stb || sram_wr_stb) |=>
      !(fb_rd_stb || fb_wr_stb || sram_rd_stb || sram_wr_stb));

  // R8: deselect returns the sequencer to command reception
  a_r8_back_to_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (state_q == ST_CMD));

endmodule

// File: rtl/spi_regif_regfile.sv
module spi_regif_regfile #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

  // R5: a strobed write lands at its address on the next clock
  a_r5_store: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/spi_regif_tx.sv
module spi_regif_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              fall,
  input  logic              at_boundary,
  input  logic              rd_phase,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] status,
  output logic              miso
);

  logic [DATA_W-1:0] tx_q, tx_d;

  always_comb begin
    tx_d = tx_q;
    if (cs_n) begin
      tx_d = status;
    end else if (fall) begin
      if (at_boundary) tx_d = rd_phase ? rd_data : '0;
      else             tx_d = {tx_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= '0;
    else        tx_q <= tx_d;
  end

  assign miso = !cs_n && tx_q[DATA_W-1];

  // R2: output shifter holds between falling serial-clock edges
  a_r2_hold_between_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !fall) |=> (tx_q == $past(tx_q)));

  // R3: status word is loaded as chip select falls
  a_r3_status_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (tx_q == $past(status)));

  // R9: deselected port drives zero
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !miso);

endmodule

// File: rtl/spi_regif.sv
module spi_regif #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [DATA_W-1:0] status_in,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              fb_rd_stb,
  output logic              fb_wr_stb,
  output logic              sram_rd_stb,
  output logic              sram_wr_stb
);

  logic              rise, fall;
  logic              byte_done, at_boundary, rd_phase;
  logic [DATA_W-1:0] byte_val, rd_data;
  logic [ADDR_W-1:0] acc_addr;

  spi_regif_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .cs_n (spi_cs_n),
    .sclk (spi_sclk),
    .rise (rise),
    .fall (fall)
  );

  spi_regif_rx #(.DATA_W(DATA_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (spi_cs_n),
    .rise       (rise),
    .mosi       (spi_mosi),
    .byte_done  (byte_done),
    .byte_val   (byte_val),
    .at_boundary(at_boundary)
  );

  spi_regif_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (spi_cs_n),
    .byte_done  (byte_done),
    .byte_val   (byte_val),
    .rd_phase   (rd_phase),
    .acc_addr   (acc_addr),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .fb_rd_stb  (fb_rd_stb),
    .fb_wr_stb  (fb_wr_stb),
    .sram_rd_stb(sram_rd_stb),
    .sram_wr_stb(sram_wr_stb)
  );

  assign wr_addr = acc_addr;

  spi_regif_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_stb),
    .waddr(acc_addr),
    .wdata(wr_data),
    .raddr(acc_addr),
    .rdata(rd_data)
  );

  spi_regif_tx #(.DATA_W(DATA_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (spi_cs_n),
    .fall       (fall),
    .at_boundary(at_boundary),
    .rd_phase   (rd_phase),
    .rd_data    (rd_data),
    .status     (status_in),
    .miso       (spi_miso)
  );

endmodule

// File: tb/sim_spi_regif.sv
module sim_spi_regif;

  localparam int HALF = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       mosi = 1'b0;
  logic       miso;
  logic [7:0] status = 8'h00;
  logic       wr_stb, fb_rd_stb, fb_wr_stb, sram_rd_stb, sram_wr_stb;
  logic [5:0] wr_addr;
  logic [7:0] wr_data;

  always #2 clk = ~clk;

  spi_regif u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_cs_n   (cs_n),
    .spi_sclk   (sclk),
    .spi_mosi   (mosi),
    .spi_miso   (miso),
    .status_in  (status),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .fb_rd_stb  (fb_rd_stb),
    .fb_wr_stb  (fb_wr_stb),
    .sram_rd_stb(sram_rd_stb),
    .sram_wr_stb(sram_wr_stb)
  );

  int n_chk = 0;
  int n_bad = 0;
  int hold_err = 0;
  int c_wr = 0, c_fbr = 0, c_fbw = 0, c_sr = 0, c_sw = 0;
  logic [5:0] last_wa = '0;
  logic [7:0] last_wd = '0;
  logic [7:0] model [64];
  logic [7:0] mo [3];
  logic [7:0] mi [3];
  bit done = 0;

  always @(negedge clk) begin
    if (wr_stb)      begin c_wr++; last_wa = wr_addr; last_wd = wr_data; end
    if (fb_rd_stb)   c_fbr++;
    if (fb_wr_stb)   c_fbw++;
    if (sram_rd_stb) c_sr++;
    if (sram_wr_stb) c_sw++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic spi_run(input int nbits, input logic [7:0] st);
    status = st;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = mo[i/8][7-(i%8)];
      repeat (HALF) @(negedge clk);
      mi[i/8][7-(i%8)] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      if (miso !== mi[i/8][7-(i%8)]) hold_err++;
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // kind: 0 reg rd, 1 reg wr, 2 fb rd, 3 fb wr, 4 sram rd, 5 sram wr
  function automatic int kind_of(input logic [7:0] c);
    if (c[7]) return c[6] ? 1 : 0;
    case ({c[6], c[5]})
      2'b01:   return 2;
      2'b11:   return 3;
      2'b00:   return 4;
      default: return 5;
    endcase
  endfunction

  task automatic do_access(input logic [7:0] cmd, input logic [7:0] dat,
                           input int nbits, input logic [7:0] st, input string tag);
    int k, w0, fr0, fw0, sr0, sw0;
    int ew, efr, efw, esr, esw;
    k = kind_of(cmd);
    w0 = c_wr; fr0 = c_fbr; fw0 = c_fbw; sr0 = c_sr; sw0 = c_sw;
    mo[0] = cmd; mo[1] = dat; mo[2] = $urandom;
    spi_run(nbits, st);
    ew  = (k == 1 && nbits >= 16) ? 1 : 0;
    efr = (k == 2 && nbits >= 8) ? 1 : 0;
    efw = (k == 3 && nbits >= 8) ? 1 : 0;
    esr = (k == 4 && nbits >= 8) ? 1 : 0;
    esw = (k == 5 && nbits >= 8) ? 1 : 0;
    if (nbits >= 8)
      check(mi[0] == st, "R3", {tag, " status byte"}, mi[0], st);
    if (nbits >= 16) begin
      if (k == 0) check(mi[1] == model[cmd[5:0]], "R4", {tag, " read data"},
                        mi[1], model[cmd[5:0]]);
      else        check(mi[1] == 8'h00, "R9", {tag, " second byte zero"}, mi[1], 0);
    end
    if (nbits >= 24)
      check(mi[2] == 8'h00, "R10", {tag, " third byte zero"}, mi[2], 0);
    check(c_wr - w0 == ew, (nbits < 16) ? "R8" : "R5", {tag, " write strobes"},
          c_wr - w0, ew);
    if (ew == 1) begin
      check(last_wa == cmd[5:0] && last_wd == dat, "R5", {tag, " strobe addr/data"},
            {last_wa, last_wd}, {cmd[5:0], dat});
      model[cmd[5:0]] = dat;
    end
    check(c_fbr - fr0 == efr && c_fbw - fw0 == efw, "R6", {tag, " fb strobes"},
          (c_fbr - fr0) * 16 + (c_fbw - fw0), efr * 16 + efw);
    check(c_sr - sr0 == esr && c_sw - sw0 == esw, "R7", {tag, " sram strobes"},
          (c_sr - sr0) * 16 + (c_sw - sw0), esr * 16 + esw);
    check(miso == 1'b0, "R9", {tag, " idle miso"}, miso, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    repeat (4) @(negedge clk);
    check(miso == 1'b0, "R1", "miso in reset", miso, 0);
    check({wr_stb, fb_rd_stb, fb_wr_stb, sram_rd_stb, sram_wr_stb} == 5'b0, "R1",
          "strobes in reset", {wr_stb, fb_rd_stb, fb_wr_stb, sram_rd_stb, sram_wr_stb}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(miso == 1'b0, "R1", "miso after reset", miso, 0);

    // R1: registers clear after reset
    do_access(8'h80 | 8'h15, 8'h00, 16, 8'h3C, "R1 reset read");
    // R5 / R2: write then read back, MSB-first data
    do_access(8'hC0 | 8'h15, 8'hA5, 16, 8'h81, "R5 write 15");
    do_access(8'h80 | 8'h15, 8'h00, 16, 8'h7E, "R4 read 15");
    do_access(8'hC0 | 8'h3F, 8'h01, 16, 8'hFF, "R5 write 3F");
    do_access(8'hC0 | 8'h00, 8'h80, 16, 8'h00, "R5 write 00");
    do_access(8'h80 | 8'h3F, 8'h00, 16, 8'h55, "R4 read 3F");
    do_access(8'h80 | 8'h00, 8'h00, 16, 8'hAA, "R4 read 00");
    // R8: aborts in data byte and in command byte
    do_access(8'hC0 | 8'h15, 8'h3C, 12, 8'h11, "R8 abort data");
    do_access(8'hC0 | 8'h15, 8'h3C, 15, 8'h22, "R8 abort bit15");
    do_access(8'hC0 | 8'h15, 8'h3C, 4, 8'h33, "R8 abort cmd");
    do_access(8'h80 | 8'h15, 8'h00, 16, 8'h44, "R8 read after abort");
    // R10: trailing byte ignored
    do_access(8'hC0 | 8'h07, 8'h5A, 24, 8'h66, "R10 three bytes");
    do_access(8'h80 | 8'h07, 8'h00, 24, 8'h99, "R10 read three bytes");
    // R6 / R7: decoded non-register commands
    do_access(8'h20 | 8'h0A, 8'hFF, 16, 8'h12, "R6 fb read");
    do_access(8'h60 | 8'h1F, 8'hFF, 16, 8'h34, "R6 fb write");
    do_access(8'h00 | 8'h05, 8'hFF, 16, 8'h56, "R7 sram read");
    do_access(8'h40 | 8'h1C, 8'hFF, 16, 8'h78, "R7 sram write");

    // Random mix, occasional aborts
    for (int t = 0; t < 250; t++) begin
      logic [7:0] c, d, s;
      int nb;
      c = $urandom;
      if ($urandom_range(0, 1) == 1) c[7] = 1'b1;
      d = $urandom;
      s = $urandom;
      nb = ($urandom_range(0, 7) == 0) ? $urandom_range(1, 15) : 16;
      do_access(c, d, nb, s, "rand");
    end

    // R5: full sweep of register contents against the model
    for (int a = 0; a < 64; a++) begin
      mo[0] = 8'h80 | 8'(a);
      mo[1] = 8'h00;
      spi_run(16, 8'(a));
      check(mi[1] == model[a], "R5", "sweep readback", mi[1], model[a]);
    end
    check(hold_err == 0, "R2", "miso stable while sclk high", hold_err, 0);
    finish_run();
  end

endmodule